// File: doc/BRIEF.md
# Unaligned Access Byte-Splitting Unit

This block sits between a load/store pipeline and a simple memory port. It takes one memory request at a time: an address, a size of 1, 2, 4, 8 or 16 bytes, an access kind, a direction, write data and a few qualifiers. From these it decides one of three outcomes:

- The request faults because it is misaligned where alignment is mandatory.
- The request is sent as one single-copy atomic transfer of the full size.
- The request is sent as a serial run of one-byte transfers at ascending addresses.

For reads, the block rebuilds the returned bytes into one little-endian word. It marks the end of every completed request with a one-cycle done strobe. Writes to shareable memory also announce the written address and size on a clear-exclusive strobe, so the exclusive monitors can drop a matching reservation.

Only one transfer is outstanding on the memory port at any time. The port uses a valid/ready issue handshake and a response strobe. The response strobe also acknowledges writes.

Top module: `split_unit`

## Requirements
- R1: An aligned request whose kind is not vector (3) or vector-streaming (4) issues exactly one transfer, at the request address, with the request's size code. Size codes are log2 of the byte count: 0=1, 1=2, 2=4, 3=8, 4=16. Kinds are 0 plain, 1 atomic, 2 ordered, 3 vector, 4 vector-streaming.
- R2: A misaligned request (address not a multiple of the size) faults when its kind is atomic (1) or ordered (2), or when `req_chk_en` is high. On a fault, `align_fault` pulses in the cycle after acceptance, no transfer is issued and no done follows.
- R3: A non-atomic request issues one transfer per byte, in order, at address+0 up to address+size-1, each with size code 0. Transfer i of a write carries request data bits 8i+7..8i in `mem_wdata[7:0]`.
- R4: An aligned vector or vector-streaming request larger than one byte is split as in R3. A one-byte request of any kind is issued as a single transfer.
- R5: With `req_bigend` high, write data is byte-reversed over the request size before issue: byte i written equals request byte size-1-i.
- R6: An exclusive request that is not faulted and would be non-atomic pulses `excl_error` in the cycle after acceptance and issues nothing.
- R7: An accepted write with `req_shared` high, and with no fault or error, pulses `clrx_valid` in the cycle after acceptance, carrying the request address and size code. Reads and non-shareable writes never pulse it.
- R8: `done` pulses one cycle after the response strobe of the final transfer. For reads, `done_rdata` holds byte i at bits 8i+7..8i and zero above the request size. For writes it is zero.
- R9: `req_ready` is high only when no request is in progress, and at most one memory transfer is outstanding.
- R10: A synchronous active-high reset returns the block to idle with `req_ready` high and `mem_valid` low, and drops any partly issued request without a done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_addr | input | ADDR_W | Request byte address |
| req_size_lg | input | 3 | log2 of request byte count |
| req_kind | input | 3 | Access kind code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 8*DATA_BYTES | Write data, little-endian byte lanes |
| req_excl | input | 1 | Exclusive access |
| req_bigend | input | 1 | Byte-reverse write data |
| req_chk_en | input | 1 | Fault any misaligned request |
| req_shared | input | 1 | Target memory is shareable |
| mem_valid | output | 1 | Transfer present on memory port |
| mem_ready | input | 1 | Memory accepts transfer |
| mem_addr | output | ADDR_W | Transfer address |
| mem_size_lg | output | 3 | log2 of transfer byte count |
| mem_write | output | 1 | Transfer direction |
| mem_wdata | output | 8*DATA_BYTES | Transfer write data |
| mem_rvalid | input | 1 | Transfer response strobe |
| mem_rdata | input | 8*DATA_BYTES | Response read data |
| done | output | 1 | Request completed |
| done_rdata | output | 8*DATA_BYTES | Assembled read data |
| align_fault | output | 1 | Alignment fault pulse |
| excl_error | output | 1 | Illegal non-atomic exclusive pulse |
| clrx_valid | output | 1 | Clear-exclusive pulse |
| clrx_addr | output | ADDR_W | Clear-exclusive address |
| clrx_size_lg | output | 3 | Clear-exclusive size code |

## Verification
The embedded assertions watch the port protocol on every cycle:
- only one transfer is outstanding, and the request path is closed while a transfer is pending;
- a stalled transfer holds its address and data;
- fault and error pulses never coincide with traffic or a done;
- done always follows a response strobe.

Some properties only the bench's sweeps can show. These are whether the choice between atomic, split and fault is correct for every size, offset, kind and check setting; the exact byte addresses and order; big-endian reversal; read assembly and masking; and the clear-exclusive contents. The sweep uses a stalling memory whose upper response bytes are junk.

// File: rtl/split_pkg.sv
package split_pkg;

   typedef enum logic [2:0] {
      KIND_PLAIN   = 3'd0,
      KIND_ATOMIC  = 3'd1,
      KIND_ORDERED = 3'd2,
      KIND_VEC     = 3'd3,
      KIND_VSTREAM = 3'd4
   } acc_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } seq_st_e;

endpackage

// File: rtl/split_classify.sv
module split_classify
   import split_pkg::*;
#(
   parameter int ADDR_W = 16
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [2:0]        size_lg,
   input  logic [2:0]        kind,
   input  logic              chk_en,
   input  logic              excl,
   output logic              fault,
   output logic              atomic_ok,
   output logic              excl_bad
);

   logic [ADDR_W-1:0] low_mask;
   logic              aligned;
   logic              strict_kind;
   logic              vec_kind;

   always_comb begin
      low_mask    = (ADDR_W'(1) << size_lg) - ADDR_W'(1);
      aligned     = (addr & low_mask) == '0;
      strict_kind = (kind == KIND_ATOMIC) || (kind == KIND_ORDERED);
      vec_kind    = (kind == KIND_VEC) || (kind == KIND_VSTREAM);
      fault       = !aligned && (strict_kind || chk_en);
      atomic_ok   = (aligned && !vec_kind) || (size_lg == 3'd0);
      excl_bad    = excl && !atomic_ok && !fault;
   end

endmodule

// File: rtl/split_byterev.sv
module split_byterev #(
   parameter int BYTES = 16
) (
   input  logic [8*BYTES-1:0] din,
   input  logic [2:0]         size_lg,
   input  logic               rev,
   output logic [8*BYTES-1:0] dout
);

   localparam int IDX_W = $clog2(BYTES);
   localparam int SZ_W  = IDX_W + 1;

   logic [SZ_W-1:0] sz;
   assign sz = SZ_W'(1) << size_lg;

   for (genvar g = 0; g < BYTES; g++) begin : g_lane
      logic [IDX_W-1:0] src;
      always_comb begin
         if (rev) src = IDX_W'(int'(sz) - 1 - g);
         else     src = IDX_W'(g);
      end
      assign dout[8*g +: 8] = (SZ_W'(g) < sz) ? din[8*src +: 8] : 8'h00;
   end

endmodule

// File: rtl/split_unit.sv
module split_unit
   import split_pkg::*;
#(
   parameter int ADDR_W     = 16,
   parameter int DATA_BYTES = 16
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    req_valid,
   output logic                    req_ready,
   input  logic [ADDR_W-1:0]       req_addr,
   input  logic [2:0]              req_size_lg,
   input  logic [2:0]              req_kind,
   input  logic                    req_write,
   input  logic [8*DATA_BYTES-1:0] req_wdata,
   input  logic                    req_excl,
   input  logic                    req_bigend,
   input  logic                    req_chk_en,
   input  logic                    req_shared,
   output logic                    mem_valid,
   input  logic                    mem_ready,
   output logic [ADDR_W-1:0]       mem_addr,
   output logic [2:0]              mem_size_lg,
   output logic                    mem_write,
   output logic [8*DATA_BYTES-1:0] mem_wdata,
   input  logic                    mem_rvalid,
   input  logic [8*DATA_BYTES-1:0] mem_rdata,
   output logic                    done,
   output logic [8*DATA_BYTES-1:0] done_rdata,
   output logic                    align_fault,
   output logic                    excl_error,
   output logic                    clrx_valid,
   output logic [ADDR_W-1:0]       clrx_addr,
   output logic [2:0]              clrx_size_lg
);

   localparam int DATA_W = 8 * DATA_BYTES;
   localparam int IDX_W  = $clog2(DATA_BYTES);
   localparam int CNT_W  = IDX_W + 1;

   if (DATA_BYTES < 2 || DATA_BYTES > 64 || (DATA_BYTES & (DATA_BYTES - 1)) != 0) begin : g_bad_bytes
      $error("split_unit: DATA_BYTES must be a power of two from 2 to 64");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("split_unit: ADDR_W too small for DATA_BYTES");
   end

   seq_st_e           st;
   logic [ADDR_W-1:0] a_addr;
   logic [2:0]        a_lg;
   logic              a_write;
   logic              a_split;
   logic [DATA_W-1:0] a_wdata;
   logic [DATA_W-1:0] rbuf;
   logic [IDX_W-1:0]  idx;
   logic              done_q, fault_q, err_q, clrx_q;
   logic [ADDR_W-1:0] clrx_addr_q;
   logic [2:0]        clrx_lg_q;

   logic              c_fault, c_atomic, c_excl_bad;
   logic [DATA_W-1:0] wsrc;
   logic [DATA_W-1:0] rd_fit;
   logic              acc;
   logic [CNT_W-1:0]  sz_q;
   logic              last_beat;

   split_classify #(.ADDR_W(ADDR_W)) u_cls (
      .addr      (req_addr),
      .size_lg   (req_size_lg),
      .kind      (req_kind),
      .chk_en    (req_chk_en),
      .excl      (req_excl),
      .fault     (c_fault),
      .atomic_ok (c_atomic),
      .excl_bad  (c_excl_bad)
   );

   split_byterev #(.BYTES(DATA_BYTES)) u_wrev (
      .din     (req_wdata),
      .size_lg (req_size_lg),
      .rev     (req_bigend && req_write),
      .dout    (wsrc)
   );

   split_byterev #(.BYTES(DATA_BYTES)) u_rfit (
      .din     (mem_rdata),
      .size_lg (a_lg),
      .rev     (1'b0),
      .dout    (rd_fit)
   );

   assign req_ready = (st == ST_IDLE);
   assign acc       = req_valid && req_ready;
   assign sz_q      = CNT_W'(1) << a_lg;
   assign last_beat = !a_split || ({1'b0, idx} == sz_q - CNT_W'(1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st      <= ST_IDLE;
         idx     <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         err_q   <= 1'b0;
         clrx_q  <= 1'b0;
         a_split <= 1'b0;
         a_write <= 1'b0;
         rbuf    <= '0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         err_q   <= 1'b0;
         clrx_q  <= 1'b0;
         case (st)
            ST_IDLE: begin
               if (acc) begin
                  fault_q <= c_fault;
                  err_q   <= c_excl_bad;
                  if (!c_fault && !c_excl_bad) begin
                     st          <= ST_ISSUE;
                     a_addr      <= req_addr;
                     a_lg        <= req_size_lg;
                     a_write     <= req_write;
                     a_split     <= !c_atomic;
                     a_wdata     <= wsrc;
                     idx         <= '0;
                     rbuf        <= '0;
                     clrx_q      <= req_write && req_shared;
                     clrx_addr_q <= req_addr;
                     clrx_lg_q   <= req_size_lg;
                  end
               end
            end
            ST_ISSUE: begin
               if (mem_ready) st <= ST_WAIT;
            end
            ST_WAIT: begin
               if (mem_rvalid) begin
                  if (!a_write) begin
                     if (a_split) rbuf[8*idx +: 8] <= mem_rdata[7:0];
                     else         rbuf <= rd_fit;
                  end
                  if (last_beat) begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                  end else begin
                     idx <= idx + IDX_W'(1);
                     st  <= ST_ISSUE;
                  end
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign mem_valid    = (st == ST_ISSUE);
   assign mem_addr     = a_addr + ADDR_W'(idx);
   assign mem_size_lg  = a_split ? 3'd0 : a_lg;
   assign mem_write    = a_write;
   assign mem_wdata    = a_split ? DATA_W'(a_wdata[8*idx +: 8]) : a_wdata;
   assign done         = done_q;
   assign done_rdata   = rbuf;
   assign align_fault  = fault_q;
   assign excl_error   = err_q;
   assign clrx_valid   = clrx_q;
   assign clrx_addr    = clrx_addr_q;
   assign clrx_size_lg = clrx_lg_q;

   // R9: a handshaken transfer is followed by a response wait, never a second issue
   a_r9_one_outstanding: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && mem_ready) |=> !mem_valid);

   // R9: the request path is closed while a transfer is presented
   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
      mem_valid |-> !req_ready);

   // R3: a stalled transfer keeps its address and data
   a_r3_hold_on_stall: assert property (@(posedge clk) disable iff (rst)
      (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) && $stable(mem_wdata)));

   // R2: a fault pulse comes with no traffic and no completion
   a_r2_fault_quiet: assert property (@(posedge clk) disable iff (rst)
      align_fault |-> (!mem_valid && !done));

   // R6: an exclusive error pulse comes with no traffic and no completion
   a_r6_err_quiet: assert property (@(posedge clk) disable iff (rst)
      excl_error |-> (!mem_valid && !done && !clrx_valid));

   // R8: completion is always preceded by a response strobe
   a_r8_done_after_resp: assert property (@(posedge clk) disable iff (rst)
      done |-> $past(mem_rvalid));

endmodule

// File: tb/sim_split_unit.sv
`timescale 1ns/1ps
module sim_split_unit;
   localparam int AW = 16;
   localparam int NB = 16;
   localparam int DW = 8 * NB;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst;
   logic req_valid, req_ready;
   logic [AW-1:0] req_addr;
   logic [2:0] req_size_lg, req_kind;
   logic req_write, req_excl, req_bigend, req_chk_en, req_shared;
   logic [DW-1:0] req_wdata;
   logic mem_valid, mem_ready, mem_write, mem_rvalid;
   logic [AW-1:0] mem_addr;
   logic [2:0] mem_size_lg;
   logic [DW-1:0] mem_wdata, mem_rdata;
   logic done, align_fault, excl_error, clrx_valid;
   logic [DW-1:0] done_rdata;
   logic [AW-1:0] clrx_addr;
   logic [2:0] clrx_size_lg;

   split_unit #(.ADDR_W(AW), .DATA_BYTES(NB)) u0 (
      .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size_lg(req_size_lg), .req_kind(req_kind),
      .req_write(req_write), .req_wdata(req_wdata), .req_excl(req_excl),
      .req_bigend(req_bigend), .req_chk_en(req_chk_en), .req_shared(req_shared),
      .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
      .mem_size_lg(mem_size_lg), .mem_write(mem_write), .mem_wdata(mem_wdata),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done),
      .done_rdata(done_rdata), .align_fault(align_fault), .excl_error(excl_error),
      .clrx_valid(clrx_valid), .clrx_addr(clrx_addr), .clrx_size_lg(clrx_size_lg)
   );

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   // memory model with stalls and junk above the transfer size
   logic [7:0] mem [0:255];
   int txn_total = 0;
   int t_addr [0:63];
   int t_lg [0:63];

   function automatic logic [7:0] init_val(int i);
      return 8'(i * 7 + 3);
   endfunction

   function automatic logic [DW-1:0] mem_read(int a, int lg);
      logic [DW-1:0] r;
      for (int j = 0; j < NB; j++)
         r[8*j +: 8] = (j < (1 << lg)) ? mem[(a + j) % 256] : 8'hEE;
      return r;
   endfunction

   always @(posedge clk) begin
      mem_rvalid <= 1'b0;
      if (rst) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      end else if (mem_valid && mem_ready) begin
         t_addr[txn_total % 64] <= int'(mem_addr);
         t_lg[txn_total % 64]   <= int'(mem_size_lg);
         txn_total <= txn_total + 1;
         mem_rvalid <= 1'b1;
         mem_rdata  <= mem_read(int'(mem_addr), int'(mem_size_lg));
         if (mem_write)
            for (int j = 0; j < NB; j++)
               if (j < (1 << mem_size_lg)) mem[(int'(mem_addr) + j) % 256] <= mem_wdata[8*j +: 8];
      end
   end

   always @(negedge clk) mem_ready <= (cyc % 3) != 1;

   // output monitor
   int done_n = 0, fault_n = 0, err_n = 0, clrx_n = 0;
   int done_cyc = 0, rv_cyc = 0, clrx_a = 0, clrx_l = 0;
   logic [DW-1:0] done_data;
   always @(negedge clk) begin
      if (done) begin done_n++; done_data = done_rdata; done_cyc = cyc; end
      if (align_fault) fault_n++;
      if (excl_error) err_n++;
      if (clrx_valid) begin clrx_n++; clrx_a = int'(clrx_addr); clrx_l = int'(clrx_size_lg); end
      if (mem_rvalid) rv_cyc = cyc;
   end

   int n_tests = 0, n_fail = 0;
   bit finished = 0;
   logic [7:0] exp_mem [0:255];

   task automatic chk(string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      end
   endtask

   task automatic reset_exp();
      for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
   endtask

   task automatic do_op(int addr, int lg, int kind, bit wr, logic [DW-1:0] wd,
                        bit ex, bit be, bit ce, bit sh);
      int sz, t0, d0, f0, e0, c0, exp_n, waited;
      bit aligned, e_fault, e_atomic, e_err, e_clr, go;
      string tag;
      logic [DW-1:0] e_rd;
      sz       = 1 << lg;
      aligned  = (addr % sz) == 0;
      e_fault  = !aligned && (kind == 1 || kind == 2 || ce);
      e_atomic = (aligned && kind != 3 && kind != 4) || sz == 1;
      e_err    = !e_fault && !e_atomic && ex;
      go       = !e_fault && !e_err;
      e_clr    = go && wr && sh;
      exp_n    = !go ? 0 : (e_atomic ? 1 : sz);
      while (!req_ready) @(negedge clk);
      @(negedge clk);
      req_valid = 1; req_addr = AW'(addr); req_size_lg = 3'(lg); req_kind = 3'(kind);
      req_write = wr; req_wdata = wd; req_excl = ex; req_bigend = be;
      req_chk_en = ce; req_shared = sh;
      @(posedge clk);
      t0 = txn_total; d0 = done_n; f0 = fault_n; e0 = err_n; c0 = clrx_n;
      @(negedge clk);
      req_valid = 0;
      chk("R9", "ready after accept", DW'(req_ready), DW'(!go));
      waited = 0;
      while (done_n == d0 && fault_n == f0 && err_n == e0 && waited < 400) begin
         @(posedge clk); waited++;
      end
      repeat (2) @(posedge clk);
      chk("R2", "fault pulses", DW'(fault_n - f0), DW'(e_fault));
      chk("R6", "excl error pulses", DW'(err_n - e0), DW'(e_err));
      chk("R8", "done pulses", DW'(done_n - d0), DW'(go));
      tag = !go ? (e_fault ? "R2" : "R6") : (e_atomic ? "R1" : ((aligned && kind >= 3) ? "R4" : "R3"));
      if (go && e_atomic && sz == 1 && kind >= 3) tag = "R4";
      chk(tag, "transfer count", DW'(txn_total - t0), DW'(exp_n));
      for (int k = 0; k < exp_n && k < 64; k++) begin
         chk(tag, "transfer addr", DW'(t_addr[(t0 + k) % 64]), DW'(addr + (e_atomic ? 0 : k)));
         chk(tag, "transfer size", DW'(t_lg[(t0 + k) % 64]), DW'(e_atomic ? lg : 0));
      end
      if (go) chk("R8", "done latency", DW'(done_cyc), DW'(rv_cyc + 1));
      if (go && !wr) begin
         for (int i = 0; i < NB; i++)
            e_rd[8*i +: 8] = (i < sz) ? exp_mem[(addr + i) % 256] : 8'h00;
         chk("R8", "read data", done_data, e_rd);
      end
      if (go && wr) begin
         chk("R8", "write done data", done_data, '0);
         for (int i = 0; i < sz; i++)
            exp_mem[(addr + i) % 256] = be ? wd[8*(sz - 1 - i) +: 8] : wd[8*i +: 8];
      end
      for (int i = 0; i < sz; i++)
         chk(be ? "R5" : (e_atomic ? "R1" : "R3"), "memory byte",
             DW'(mem[(addr + i) % 256]), DW'(exp_mem[(addr + i) % 256]));
      chk("R7", "clear-exclusive pulses", DW'(clrx_n - c0), DW'(e_clr));
      if (e_clr) begin
         chk("R7", "clear-exclusive addr", DW'(clrx_a), DW'(addr));
         chk("R7", "clear-exclusive size", DW'(clrx_l), DW'(lg));
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL R9 watchdog: actual hung expected finish");
      summary();
      $finish;
   end

   initial begin
      int d0;
      rst = 1; req_valid = 0; req_addr = '0; req_size_lg = '0; req_kind = '0;
      req_write = 0; req_wdata = '0; req_excl = 0; req_bigend = 0;
      req_chk_en = 0; req_shared = 0;
      reset_exp();
      repeat (3) @(posedge clk);
      @(negedge clk); rst = 0;
      // R10 reset state
      chk("R10", "ready after reset", DW'(req_ready), DW'(1));
      chk("R10", "mem_valid after reset", DW'(mem_valid), DW'(0));
      chk("R10", "done after reset", DW'(done), DW'(0));

      // R10: reset in the middle of a split read drops it
      @(negedge clk);
      req_valid = 1; req_addr = AW'(33); req_size_lg = 3'd4; req_kind = 3'd0; req_write = 0;
      @(posedge clk); d0 = done_n;
      @(negedge clk); req_valid = 0;
      repeat (7) @(posedge clk);
      @(negedge clk); rst = 1;
      @(negedge clk); rst = 0;
      chk("R10", "ready after mid reset", DW'(req_ready), DW'(1));
      chk("R10", "mem_valid after mid reset", DW'(mem_valid), DW'(0));
      repeat (20) @(posedge clk);
      chk("R10", "no done after dropped request", DW'(done_n - d0), DW'(0));
      reset_exp();

      // main sweep: sizes, offsets, kinds, directions, check enable
      for (int lg = 0; lg < 5; lg++)
         for (int off = 0; off < 4; off++)
            for (int kind = 0; kind < 5; kind++)
               for (int wr = 0; wr < 2; wr++)
                  for (int ce = 0; ce < 2; ce++)
                     do_op(32 * lg + off, lg, kind, bit'(wr),
                           {$urandom, $urandom, $urandom, $urandom},
                           1'b0, bit'((off + lg) % 2), bit'(ce), bit'((kind + off) % 2));

      // R6 exclusive sweep
      for (int lg = 0; lg < 5; lg++)
         for (int off = 0; off < 4; off++)
            for (int kind = 0; kind < 5; kind++)
               for (int wr = 0; wr < 2; wr++)
                  do_op(32 * lg + 5 + off, lg, kind, bit'(wr),
                        {$urandom, $urandom, $urandom, $urandom},
                        1'b1, bit'(wr), 1'b0, 1'b1);

      summary();
      $finish;
   end
endmodule